// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte-Lane Write Control

This block is a clocked single-port memory that follows the conventions of a pipelined burst static RAM. Two active-low load strobes capture an external address into an internal register whose lowest two bits act as a wrapping burst counter. A separate active-low step input moves through four consecutive words. Holding the step input high suspends the burst.

The two load strobes differ in how they treat writes. The first strobe never writes on its own edge, so data for that address comes on later beats. The second strobe can write on the edge that loads it, which lets a controller restart or extend a write burst at a new address without an idle cycle.

Each 36-bit word is split into four 9-bit lanes. A global write input writes every lane. Otherwise a lane-gate input together with four per-lane enables picks which lanes are written. Three chip selects gate every new load. A read-enable input controls the registered read path, and the block reports through a drive-enable output when the read bus would be driven.

Top module: `sync_burst_sram`

## Requirements
- R1: After a synchronous reset no burst is active, and `rdata_oe` stays low until a selected load occurs.
- R2: An edge with `load_a_n` low while selected loads `addr` and starts a burst. All write inputs are ignored on that edge, and the stored words do not change. When both strobes are low, `load_a_n` takes priority.
- R3: An edge with `load_b_n` low while selected (and `load_a_n` high) loads `addr` and restarts the burst. If a write is requested on that edge, `wdata` is written to the newly loaded address.
- R4: On an edge with no load and `step_n` low during an active burst, address bits [1:0] increase by one modulo 4 and the upper address bits are held.
- R5: On an edge with no load and `step_n` high, the burst address is held.
- R6: A write on a non-load edge of an active burst goes to the address after that edge's step. The first beat therefore lands on the loaded address only when `step_n` is high.
- R7: All four lanes are written when `wr_global_n` is low. All four lanes are also written when `wr_global_n` is high, `wr_lane_gate_n` is low and all of `lane_wr_n` are low.
- R8: With `wr_global_n` high and `wr_lane_gate_n` low, only lanes whose `lane_wr_n` bit is low are written. Lane i occupies `wdata[9i+8:9i]`. With both `wr_global_n` and `wr_lane_gate_n` high, nothing is written.
- R9: The block counts as selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A `load_a_n` edge while deselected is ignored, and the burst continues as if no load were present.
- R10: A `load_b_n` edge while deselected ends the burst. Later non-load edges neither write nor drive the read path until the next selected load.
- R11: After an edge that loads or steps an active burst without writing, `rdata` holds the word at the resulting address. `rdata_oe` is high only when `rd_en_n` is low and the last edge was such a read beat, so it is low after every write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_a_n | input | 1 | Load strobe that never writes on its own edge, active low |
| load_b_n | input | 1 | Load strobe that may write on its own edge, active low |
| step_n | input | 1 | Burst advance, active low; high suspends |
| wr_global_n | input | 1 | Write all lanes, active low |
| wr_lane_gate_n | input | 1 | Enables per-lane writes, active low |
| lane_wr_n | input | 4 | Per-lane write enables, active low |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| rd_en_n | input | 1 | Read drive enable, active low |
| addr | input | 6 | Word address |
| wdata | input | 36 | Write data, four 9-bit lanes |
| rdata | output | 36 | Registered read data |
| rdata_oe | output | 1 | High when the read bus would be driven |

## Verification
A wrong burst counter or a latched upper address shows up on `rdata` after the very next read beat: the bench compares every beat with a reference array, and every start offset is swept so each wrap point is covered. A wrong lane mask does not show at once. It appears only when the damaged word is read back in a later burst, so every write sweep is followed by a full readback. A wrong select or drop state shows at `rdata_oe` one edge later, or as a word that changes when it should not.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [1:0] {
    ACT_BEAT   = 2'd0,
    ACT_LOAD_A = 2'd1,
    ACT_LOAD_B = 2'd2,
    ACT_DROP   = 2'd3
  } act_e;
endpackage

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_a_n,
  input  logic              load_b_n,
  input  logic              step_n,
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  output act_e              act,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              wr_ok,
  output logic              access_ok
);
  localparam int HI_W = ADDR_W - CNT_W;

  logic [HI_W-1:0]  base_q;
  logic [CNT_W-1:0] cnt_q;
  logic             active_q;
  logic [CNT_W-1:0] next_cnt;

  always_comb begin
    if (!load_a_n && sel)  act = ACT_LOAD_A;
    else if (!load_b_n)    act = sel ? ACT_LOAD_B : ACT_DROP;
    else                   act = ACT_BEAT;
  end

  assign next_cnt = step_n ? cnt_q : CNT_W'(cnt_q + 1'b1);

  always_comb begin
    if (act == ACT_LOAD_A || act == ACT_LOAD_B) eff_addr = addr;
    else                                        eff_addr = {base_q, next_cnt};
  end

  assign wr_ok     = (act == ACT_LOAD_B) || (act == ACT_BEAT && active_q);
  assign access_ok = (act == ACT_LOAD_A) || wr_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else begin
      case (act)
        ACT_LOAD_A, ACT_LOAD_B: begin
          base_q   <= addr[ADDR_W-1:CNT_W];
          cnt_q    <= addr[CNT_W-1:0];
          active_q <= 1'b1;
        end
        ACT_DROP: active_q <= 1'b0;
        default: if (active_q) cnt_q <= next_cnt;
      endcase
    end
  end

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_LOAD_A || act == ACT_LOAD_B) |=> ({base_q, cnt_q} == $past(addr))); // R2
  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_BEAT && step_n) |=> $stable({base_q, cnt_q})); // R5
  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_BEAT && active_q && !step_n)
      |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)) && $stable(base_q)); // R4
endmodule

// File: rtl/sbs_wdec.sv
module sbs_wdec #(
  parameter int LANES = 4
) (
  input  logic             wr_global_n,
  input  logic             wr_lane_gate_n,
  input  logic [LANES-1:0] lane_wr_n,
  output logic [LANES-1:0] mask
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign mask[i] = !wr_global_n || (!wr_lane_gate_n && !lane_wr_n[i]);
  end
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        we,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 2 ** ADDR_W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (we[i]) mem[addr] <= wdata[i*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (rst) rd_q <= '0;
      else     rd_q <= mem[addr];
    end

    assign rdata[i*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 2,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load_a_n,
  input  logic                    load_b_n,
  input  logic                    step_n,
  input  logic                    wr_global_n,
  input  logic                    wr_lane_gate_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    rd_en_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_oe
);
  logic              sel;
  act_e              act;
  logic [ADDR_W-1:0] eff_addr;
  logic              wr_ok;
  logic              access_ok;
  logic [LANES-1:0]  mask;
  logic [LANES-1:0]  lane_we;
  logic              rd_valid_q;

  assign sel = !sel_a_n && sel_b && !sel_c_n;

  sbs_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .load_a_n  (load_a_n),
    .load_b_n  (load_b_n),
    .step_n    (step_n),
    .sel       (sel),
    .addr      (addr),
    .act       (act),
    .eff_addr  (eff_addr),
    .wr_ok     (wr_ok),
    .access_ok (access_ok)
  );

  sbs_wdec #(.LANES(LANES)) i_wdec (
    .wr_global_n    (wr_global_n),
    .wr_lane_gate_n (wr_lane_gate_n),
    .lane_wr_n      (lane_wr_n),
    .mask           (mask)
  );

  assign lane_we = wr_ok ? mask : '0;

  sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_array (
    .clk   (clk),
    .rst   (rst),
    .addr  (eff_addr),
    .we    (lane_we),
    .wdata (wdata),
    .rdata (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_valid_q <= 1'b0;
    else     rd_valid_q <= access_ok && (lane_we == '0);
  end

  assign rdata_oe = !rd_en_n && rd_valid_q;

  AST_LOAD_A_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!load_a_n && sel) |-> (lane_we == '0)); // R2
  AST_DROP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!load_b_n && !sel) |=> !rdata_oe); // R10
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (lane_we != '0) |=> !rdata_oe); // R11
endmodule

// File: tb/test_sync_burst_sram.sv
module test_sync_burst_sram;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int W  = 36;
  localparam int DEPTH = 2 ** AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load_a_n = 1'b1, load_b_n = 1'b1, step_n = 1'b1;
  logic wr_global_n = 1'b1, wr_lane_gate_n = 1'b1;
  logic [3:0] lane_wr_n = 4'hF;
  logic sel_a_n = 1'b0, sel_b = 1'b1, sel_c_n = 1'b0;
  logic rd_en_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic rdata_oe;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  logic [W-1:0] refm [DEPTH];
  logic [AW-1:0] mb = '0;
  logic mact = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_burst_sram i_sync_burst_sram (
    .clk(clk), .rst(rst), .load_a_n(load_a_n), .load_b_n(load_b_n),
    .step_n(step_n), .wr_global_n(wr_global_n), .wr_lane_gate_n(wr_lane_gate_n),
    .lane_wr_n(lane_wr_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .rd_en_n(rd_en_n), .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pat(int a, int s);
    return W'((a + 1) * 36'h0_1F3D5 + s * 36'h2_7A1B3) ^ {4{9'h0A5}};
  endfunction

  // cs = {sel_a_n, sel_b, sel_c_n}; 3'b010 is the only selected code (R9)
  task automatic tick(string tag, logic la_n, logic lb_n, logic st_n, logic g_n,
                      logic e_n, logic [3:0] ln_n, logic [2:0] cs,
                      logic [AW-1:0] a, logic [W-1:0] d);
    logic sel, wr, acc;
    logic [3:0] m;
    logic [AW-1:0] ea;
    sel = (cs == 3'b010);
    m = !g_n ? 4'hF : (!e_n ? ~ln_n : 4'h0);
    wr = 1'b0; acc = 1'b0; ea = '0;
    if (!la_n && sel) begin
      mb = a; mact = 1'b1; acc = 1'b1; ea = a;
    end else if (!lb_n) begin
      if (sel) begin mb = a; mact = 1'b1; acc = 1'b1; wr = (m != 0); ea = a; end
      else mact = 1'b0;
    end else if (mact) begin
      if (!st_n) mb[1:0] = mb[1:0] + 2'd1;
      acc = 1'b1; wr = (m != 0); ea = mb;
    end
    load_a_n = la_n; load_b_n = lb_n; step_n = st_n;
    wr_global_n = g_n; wr_lane_gate_n = e_n; lane_wr_n = ln_n;
    {sel_a_n, sel_b, sel_c_n} = cs;
    addr = a; wdata = d;
    rd_en_n = wr;
    @(posedge clk);
    @(negedge clk);
    if (wr)
      for (int l = 0; l < 4; l++)
        if (m[l]) refm[ea][l*9 +: 9] = d[l*9 +: 9];
    chk({tag, " R11 oe"}, W'(rdata_oe), W'(acc && !wr));
    if (acc && !wr) chk({tag, " data"}, rdata, refm[ea]);
  endtask

  task automatic idle(string tag);
    tick(tag, 1, 1, 1, 1, 1, 4'hF, 3'b010, '0, '0);
  endtask

  task automatic read_burst(string tag, logic [AW-1:0] s);
    tick(tag, 0, 1, 1, 1, 1, 4'hF, 3'b010, s, '0);
    for (int j = 0; j < 3; j++) tick(tag, 1, 1, 0, 1, 1, 4'hF, 3'b010, '0, '0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset oe", W'(rdata_oe), '0);
    idle("R1");

    // R3 fill each word with a load_b write on the load edge
    for (int a = 0; a < DEPTH; a++)
      tick("R3", 1, 0, 1, 0, 1, 4'hF, 3'b010, AW'(a), pat(a, 0));

    // R2 load_a with a global write request: nothing written; R4 steps wrap
    for (int s = 0; s < DEPTH; s++) begin
      tick("R2", 0, 1, 1, 0, 0, 4'h0, 3'b010, AW'(s), pat(s, 9));
      for (int j = 0; j < 3; j++) tick("R4", 1, 1, 0, 1, 1, 4'hF, 3'b010, '0, '0);
    end

    // R5 suspend interleaved with steps
    for (int s = 0; s < 16; s++) begin
      tick("R2", 0, 1, 1, 1, 1, 4'hF, 3'b010, AW'(s*4 + (s % 4)), '0);
      tick("R5", 1, 1, 1, 1, 1, 4'hF, 3'b010, '0, '0);
      tick("R4", 1, 1, 0, 1, 1, 4'hF, 3'b010, '0, '0);
      tick("R5", 1, 1, 1, 1, 1, 4'hF, 3'b010, '0, '0);
    end

    // R6/R8 write bursts with varied lane controls, first beat step varies
    for (int k = 0; k < DEPTH; k++) begin
      tick("R2", 0, 1, 1, 1, 0, 4'h0, 3'b010, AW'(k), pat(k, 5));
      for (int j = 0; j < 4; j++) begin
        int idx;
        idx = k * 4 + j;
        tick("R8", 1, 1, (j == 0) ? logic'(k % 2) : 1'b0,
             (idx % 5 == 0) ? 1'b0 : 1'b1, (idx % 3 == 2) ? 1'b1 : 1'b0,
             4'(idx), 3'b010, '0, pat(idx, 3));
      end
      read_burst("R6", AW'(k));
    end

    // R7 full width via lane gate with all lanes enabled
    for (int a = 0; a < 8; a++) begin
      tick("R7", 0, 1, 1, 1, 1, 4'hF, 3'b010, AW'(a * 8), '0);
      tick("R7", 1, 1, 1, 1, 0, 4'h0, 3'b010, '0, pat(a, 77));
      tick("R7", 1, 1, 1, 1, 1, 4'hF, 3'b010, '0, '0);
    end

    // R2 priority: both strobes low, load_a wins and no write happens
    tick("R2", 0, 0, 1, 0, 0, 4'h0, 3'b010, 6'd21, pat(21, 55));
    read_burst("R2", 6'd21);

    // R9 deselected load_a ignored; R10 deselected load_b ends the burst
    for (int c = 0; c < 8; c++) begin
      if (c != 2) begin
        tick("R9", 0, 1, 1, 1, 1, 4'hF, 3'b010, 6'd8, '0);
        tick("R9", 0, 1, 0, 1, 1, 4'hF, 3'(c), 6'd40, '0);
        tick("R9", 1, 1, 0, 1, 1, 4'hF, 3'b010, '0, '0);
        tick("R10", 1, 0, 1, 1, 1, 4'hF, 3'(c), 6'd50, '0);
        tick("R10", 1, 1, 1, 0, 1, 4'hF, 3'b010, '0, pat(c, 99));
        tick("R10", 1, 1, 0, 0, 1, 4'hF, 3'b010, '0, pat(c, 98));
        tick("R10", 1, 0, 1, 0, 1, 4'hF, 3'(c), 6'd50, pat(c, 97));
        read_burst("R10", 6'd8);
        read_burst("R10", 6'd48);
      end
    end

    // R8 no lane written when global and gate are both high
    tick("R8", 0, 1, 1, 1, 1, 4'hF, 3'b010, 6'd33, '0);
    tick("R8", 1, 1, 1, 1, 1, 4'h0, 3'b010, '0, pat(33, 1));
    read_burst("R8", 6'd33);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule